// File: doc/BRIEF.md
# IPv4 TCP/UDP Checksum Inserter

This block sits on the transmit path in front of the MAC framing logic. It accepts one outgoing Ethernet frame at a time as a byte stream, starting at the destination address and ending before the CRC. The frame arrives with three per-frame enable bits: one for the IPv4 header checksum, one for the TCP checksum and one for the UDP checksum. While the frame streams in, the block stores it, decodes the EtherType and the IPv4 header, and keeps running one's-complement sums.

Once the last byte is in, the block folds and inverts the sums and then replays the stored frame. It overwrites the checksum fields whose enable bit is set and whose protocol was detected. Everything else leaves the block exactly as it came in. The output is a gapless burst with first and last byte markers. A new frame is accepted only after the previous burst has left.

Top module: `csum_inserter`

## Requirements
- R1: After reset, out_valid, out_sof and out_eof are low and no byte is emitted until a frame has been received.
- R2: Every received frame is replayed once, with the same length and byte order. The replay is one contiguous burst with out_sof on the first byte only and out_eof on the last byte only, and it starts after the input frame has ended.
- R3: A frame is IPv4 when bytes 12-13 hold 0x0800, the upper nibble of byte 14 is 4, and the lower nibble of byte 14 (header length in 32-bit words) is at least 5. With the IP enable set on an IPv4 frame, bytes 24-25 are replaced by the inverted 16-bit one's-complement sum of the header words, counted with that field as zero (high byte first).
- R4: With the TCP enable set, an IPv4 frame whose protocol byte (byte 23) is 6 gets a TCP checksum at transport offset 16-17. The transport part starts at byte 14 plus the header length. The sum covers the source and destination addresses (bytes 26-33), the protocol, and the transport length (IP total length at bytes 16-17 minus the header length). It also covers the segment up to the IP total length, with an odd last byte padded with zero and the checksum field counted as zero.
- R5: With the UDP enable set, an IPv4 frame whose protocol byte is 17 gets a UDP checksum at transport offset 6-7, computed as in R4. A result of 0x0000 is sent as 0xFFFF.
- R6: TCP and UDP checksums are inserted only when the 13-bit fragment offset (low 5 bits of byte 20 and all of byte 21) is zero. The IP header checksum is still inserted on later fragments.
- R7: The three enable bits are sampled only with the first byte of a frame. Their values during the rest of the frame have no effect.
- R8: A frame that is not IPv4, whose enable bits are clear, or whose protocol does not match the enabled checksum leaves the block unchanged.
- R9: Bytes after the IP total length, such as Ethernet padding, are not part of any checksum and are passed through unchanged.
- R10: Input bytes presented while a frame is being replayed are ignored. They produce no output and do not affect the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte qualifier |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| in_data | input | 8 | Input frame byte |
| in_ip_en | input | 1 | Insert IPv4 header checksum (sampled with first byte) |
| in_tcp_en | input | 1 | Insert TCP checksum (sampled with first byte) |
| in_udp_en | input | 1 | Insert UDP checksum (sampled with first byte) |
| out_valid | output | 1 | Output byte qualifier |
| out_sof | output | 1 | First byte of the replayed frame |
| out_eof | output | 1 | Last byte of the replayed frame |
| out_data | output | 8 | Output frame byte |

## Verification
The bench sweeps every combination of the three enables against TCP, UDP and other protocols. It runs whole and later-fragment frames, odd and even payload lengths, and two header lengths. The input frames carry garbage in their checksum fields, so a design that forgot to zero a field before summing would emit wrong sums. Short frames carry padding after the IP total length, so a design that summed to the frame end would corrupt TCP and UDP results. Frames are also built so the UDP sum comes out to zero, which exposes a missing 0xFFFF substitution. The enables are inverted after the first byte of every frame and stray bytes are driven during replay, so sampling the enables late or accepting input while busy would show up as changed or extra output.

// File: rtl/csum_ins_pkg.sv
package csum_ins_pkg;

    typedef enum logic [1:0] {
        ST_RECV  = 2'd0,
        ST_FINAL = 2'd1,
        ST_SEND  = 2'd2
    } ins_state_e;

    typedef struct packed {
        logic ip;
        logic tcp;
        logic udp;
    } csum_ctl_t;

    typedef struct packed {
        logic [15:0] ethertype;
        logic [3:0]  version;
        logic [3:0]  ihl;
        logic [15:0] total_len;
        logic [12:0] frag_off;
        logic [7:0]  proto;
    } ip_hdr_t;

    // Extended position width, wide enough for 14 + a 16-bit IP length.
    localparam int XW = 17;

    localparam int L2_LEN     = 14;
    localparam int OFS_ETYPE  = 12;
    localparam int OFS_VIHL   = 14;
    localparam int OFS_TLEN   = 16;
    localparam int OFS_FRAG   = 20;
    localparam int OFS_PROTO  = 23;
    localparam int OFS_IPCS   = 24;
    localparam int OFS_ADDR_LO = 26;
    localparam int OFS_ADDR_HI = 33;
    localparam int TCP_CS_OFS = 16;
    localparam int UDP_CS_OFS = 6;

    localparam logic [7:0]  PROTO_TCP  = 8'd6;
    localparam logic [7:0]  PROTO_UDP  = 8'd17;
    localparam logic [15:0] ETYPE_IPV4 = 16'h0800;

    // Reduce a 32-bit one's-complement accumulator to 16 bits.
    function automatic logic [15:0] fold16(input logic [31:0] s);
        logic [16:0] a;
        logic [16:0] b;
        a = {1'b0, s[15:0]} + {1'b0, s[31:16]};
        b = {1'b0, a[15:0]} + {16'd0, a[16]};
        return b[15:0];
    endfunction

    // Even frame positions carry the high byte of a 16-bit word.
    function automatic logic [31:0] word_part(input logic [7:0] b, input logic odd);
        return odd ? {24'd0, b} : {16'd0, b, 8'd0};
    endfunction

endpackage

// File: rtl/csum_frame_store.sv
module csum_frame_store #(
    parameter int DEPTH = 1514,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (wr_addr < AW'(DEPTH)))
            mem[wr_addr] <= wr_data;
    end

    assign rd_data = (rd_addr < AW'(DEPTH)) ? mem[rd_addr] : 8'h00;

endmodule

// File: rtl/csum_hdr_parse.sv
module csum_hdr_parse
    import csum_ins_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic          first,
    input  logic [AW-1:0] pos,
    input  logic [7:0]    data,
    output ip_hdr_t       hdr,
    output logic          is_ipv4
);
    ip_hdr_t hdr_q;

    always_ff @(posedge clk) begin
        if (rst || (take && first)) begin
            hdr_q <= '0;
        end else if (take) begin
            case (pos)
                AW'(OFS_ETYPE):     hdr_q.ethertype[15:8] <= data;
                AW'(OFS_ETYPE + 1): hdr_q.ethertype[7:0]  <= data;
                AW'(OFS_VIHL): begin
                    hdr_q.version <= data[7:4];
                    hdr_q.ihl     <= data[3:0];
                end
                AW'(OFS_TLEN):      hdr_q.total_len[15:8] <= data;
                AW'(OFS_TLEN + 1):  hdr_q.total_len[7:0]  <= data;
                AW'(OFS_FRAG):      hdr_q.frag_off[12:8]  <= data[4:0];
                AW'(OFS_FRAG + 1):  hdr_q.frag_off[7:0]   <= data;
                AW'(OFS_PROTO):     hdr_q.proto           <= data;
                default: ;
            endcase
        end
    end

    assign hdr     = hdr_q;
    assign is_ipv4 = (hdr_q.ethertype == ETYPE_IPV4) && (hdr_q.version == 4'd4)
                     && (hdr_q.ihl >= 4'd5);

    // Header fields are frozen once the protocol byte has gone by.
    assert_hdr_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        (take && !first && (pos > AW'(OFS_PROTO))) |=> $stable(hdr_q));

endmodule

// File: rtl/csum_accum.sv
module csum_accum
    import csum_ins_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic          first,
    input  logic [AW-1:0] pos,
    input  logic [7:0]    data,
    input  logic [3:0]    ihl,
    input  logic [15:0]   total_len,
    input  logic [7:0]    proto,
    output logic [31:0]   ip_acc,
    output logic [31:0]   l4_acc
);
    logic [XW-1:0] xpos, hlen, l4_start, l4_end, l4_cs;
    logic          in_iph, ip_field, in_l4, l4_field, in_addr;
    logic [31:0]   part, ip_add, l4_add;
    logic [31:0]   ip_q, l4_q;

    always_comb begin
        xpos     = XW'(pos);
        hlen     = XW'({ihl, 2'b00});
        l4_start = XW'(L2_LEN) + hlen;
        l4_end   = XW'(L2_LEN) + XW'(total_len);
        l4_cs    = l4_start + ((proto == PROTO_UDP) ? XW'(UDP_CS_OFS) : XW'(TCP_CS_OFS));
        in_iph   = (xpos == XW'(OFS_VIHL)) ||
                   ((xpos > XW'(OFS_VIHL)) && (xpos < l4_start));
        ip_field = (xpos == XW'(OFS_IPCS)) || (xpos == XW'(OFS_IPCS + 1));
        in_l4    = (xpos > XW'(OFS_ADDR_HI)) && (xpos >= l4_start) && (xpos < l4_end);
        l4_field = (xpos == l4_cs) || (xpos == l4_cs + 1'b1);
        in_addr  = (xpos >= XW'(OFS_ADDR_LO)) && (xpos <= XW'(OFS_ADDR_HI));
        part     = word_part(data, pos[0]);
        ip_add   = (in_iph && !ip_field) ? part : 32'd0;
        l4_add   = ((in_l4 && !l4_field) || in_addr) ? part : 32'd0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ip_q <= '0;
            l4_q <= '0;
        end else if (take) begin
            if (first) begin
                ip_q <= '0;
                l4_q <= '0;
            end else begin
                ip_q <= ip_q + ip_add;
                l4_q <= l4_q + l4_add;
            end
        end
    end

    assign ip_acc = ip_q;
    assign l4_acc = l4_q;

endmodule

// File: rtl/csum_inserter.sv
module csum_inserter
    import csum_ins_pkg::*;
#(
    parameter int MAX_LEN = 1514
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_sof,
    input  logic       in_eof,
    input  logic [7:0] in_data,
    input  logic       in_ip_en,
    input  logic       in_tcp_en,
    input  logic       in_udp_en,
    output logic       out_valid,
    output logic       out_sof,
    output logic       out_eof,
    output logic [7:0] out_data
);
    localparam int AW = $clog2(MAX_LEN + 1);

    ins_state_e    state;
    logic          active_q;
    logic [AW-1:0] wr_pos, len_q, rd_pos, byte_pos;
    csum_ctl_t     ctl_q;
    logic [15:0]   ip_cs_q, l4_cs_q;
    logic          do_ip_q, do_l4_q, do_udp_q;
    logic [XW-1:0] l4_pos_q;

    logic          take, at_cap;
    ip_hdr_t       hdr;
    logic          is_ipv4;
    logic [31:0]   ip_acc, l4_acc;
    logic [7:0]    rd_byte, send_byte;

    // Finalisation terms
    logic          first_frag, sel_tcp, sel_udp;
    logic [15:0]   hlen16, tlen16, l4_fin;
    logic [31:0]   l4_raw;
    logic [XW-1:0] l4_pos_n;
    logic          last;

    assign take     = in_valid && (state == ST_RECV) && (in_sof || active_q);
    assign byte_pos = in_sof ? '0 : wr_pos;
    assign at_cap   = byte_pos >= AW'(MAX_LEN);

    csum_frame_store #(.DEPTH(MAX_LEN), .AW(AW)) u_store (
        .clk     (clk),
        .wr_en   (take && !at_cap),
        .wr_addr (byte_pos),
        .wr_data (in_data),
        .rd_addr (rd_pos),
        .rd_data (rd_byte)
    );

    csum_hdr_parse #(.AW(AW)) u_parse (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .first   (in_sof),
        .pos     (byte_pos),
        .data    (in_data),
        .hdr     (hdr),
        .is_ipv4 (is_ipv4)
    );

    csum_accum #(.AW(AW)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .first     (in_sof),
        .pos       (byte_pos),
        .data      (in_data),
        .ihl       (hdr.ihl),
        .total_len (hdr.total_len),
        .proto     (hdr.proto),
        .ip_acc    (ip_acc),
        .l4_acc    (l4_acc)
    );

    always_comb begin
        first_frag = (hdr.frag_off == 13'd0);
        sel_tcp    = ctl_q.tcp && is_ipv4 && first_frag && (hdr.proto == PROTO_TCP);
        sel_udp    = ctl_q.udp && is_ipv4 && first_frag && (hdr.proto == PROTO_UDP);
        hlen16     = {10'd0, hdr.ihl, 2'b00};
        tlen16     = hdr.total_len - hlen16;
        l4_raw     = l4_acc + {24'd0, hdr.proto} + {16'd0, tlen16};
        l4_fin     = ~fold16(l4_raw);
        if (sel_udp && (l4_fin == 16'h0000))
            l4_fin = 16'hFFFF;
        l4_pos_n   = XW'(L2_LEN) + XW'(hlen16)
                     + (sel_udp ? XW'(UDP_CS_OFS) : XW'(TCP_CS_OFS));
    end

    always_comb begin
        send_byte = rd_byte;
        if (do_ip_q && (rd_pos == AW'(OFS_IPCS)))
            send_byte = ip_cs_q[15:8];
        if (do_ip_q && (rd_pos == AW'(OFS_IPCS + 1)))
            send_byte = ip_cs_q[7:0];
        if (do_l4_q && (XW'(rd_pos) == l4_pos_q))
            send_byte = l4_cs_q[15:8];
        if (do_l4_q && (XW'(rd_pos) == l4_pos_q + 1'b1))
            send_byte = l4_cs_q[7:0];
    end

    assign last = (rd_pos == len_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_RECV;
            active_q  <= 1'b0;
            wr_pos    <= '0;
            len_q     <= '0;
            rd_pos    <= '0;
            ctl_q     <= '0;
            ip_cs_q   <= '0;
            l4_cs_q   <= '0;
            do_ip_q   <= 1'b0;
            do_l4_q   <= 1'b0;
            do_udp_q  <= 1'b0;
            l4_pos_q  <= '0;
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            out_data  <= 8'h00;
        end else begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            unique case (state)
                ST_RECV: begin
                    if (take) begin
                        if (in_sof)
                            ctl_q <= {in_ip_en, in_tcp_en, in_udp_en};
                        wr_pos   <= at_cap ? byte_pos : byte_pos + 1'b1;
                        active_q <= !in_eof;
                        if (in_eof) begin
                            len_q <= at_cap ? AW'(MAX_LEN) : byte_pos + 1'b1;
                            state <= ST_FINAL;
                        end
                    end
                end
                ST_FINAL: begin
                    ip_cs_q  <= ~fold16(ip_acc);
                    l4_cs_q  <= l4_fin;
                    do_ip_q  <= ctl_q.ip && is_ipv4;
                    do_l4_q  <= sel_tcp || sel_udp;
                    do_udp_q <= sel_udp;
                    l4_pos_q <= l4_pos_n;
                    rd_pos   <= '0;
                    state    <= ST_SEND;
                end
                ST_SEND: begin
                    out_valid <= 1'b1;
                    out_data  <= send_byte;
                    out_sof   <= (rd_pos == '0);
                    out_eof   <= last;
                    if (last)
                        state <= ST_RECV;
                    else
                        rd_pos <= rd_pos + 1'b1;
                end
                default: state <= ST_RECV;
            endcase
        end
    end

    assert_sof_valid_R2: assert property (@(posedge clk) disable iff (rst)
        (out_sof || out_eof) |-> out_valid);

    assert_burst_gapless_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_eof) |=> out_valid);

    assert_udp_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_SEND) && do_udp_q) |-> (l4_cs_q != 16'h0000));

    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEND) |=> ($stable(ip_acc) && $stable(l4_acc)));

endmodule

// File: tb/sim_csum_inserter.sv
module sim_csum_inserter;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid, in_sof, in_eof;
    logic [7:0] in_data;
    logic       in_ip_en, in_tcp_en, in_udp_en;
    logic       out_valid, out_sof, out_eof;
    logic [7:0] out_data;

    always #4 clk = ~clk;

    csum_inserter u0 (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .in_ip_en(in_ip_en), .in_tcp_en(in_tcp_en), .in_udp_en(in_udp_en),
        .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof), .out_data(out_data)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    logic [7:0] fr [0:255];
    logic [7:0] exb [0:255];
    logic [7:0] got [0:511];
    int flen;
    int gcnt, eof_cnt, eof_idx, sof_err;

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected < 190000)", cycles);
            finish_run();
        end
    end

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (gcnt < 512) got[gcnt] = out_data;
            if (out_sof != (gcnt == 0)) sof_err++;
            if (out_eof) begin eof_cnt++; eof_idx = gcnt; end
            gcnt++;
        end
    end

    function automatic logic [15:0] fold(input logic [31:0] s);
        logic [31:0] t;
        t = s;
        while (t > 32'hFFFF) t = (t & 32'hFFFF) + (t >> 16);
        return t[15:0];
    endfunction

    // Folded (not inverted) transport sum with field at cpos taken as zero.
    function automatic logic [15:0] l4_sum(input int cpos);
        logic [31:0] s;
        int hl, tl, st, en;
        logic [7:0] hi, lo;
        hl = fr[14][3:0] * 4;
        tl = {fr[16], fr[17]};
        st = 14 + hl;
        en = 14 + tl;
        s = 0;
        for (int i = 26; i < 34; i += 2) s += {fr[i], fr[i+1]};
        s += fr[23];
        s += (tl - hl);
        for (int i = st; i < en; i += 2) begin
            hi = (i == cpos) ? 8'h00 : fr[i];
            lo = ((i + 1 >= en) || (i == cpos)) ? 8'h00 : fr[i+1];
            s += {hi, lo};
        end
        return fold(s);
    endfunction

    // Expected output: ctl = {ip, tcp, udp}
    task automatic model(input logic [2:0] ctl);
        logic ipv4;
        int hl, cpos;
        logic [31:0] s;
        logic [15:0] c;
        logic [12:0] foff;
        for (int i = 0; i < flen; i++) exb[i] = fr[i];
        ipv4 = (fr[12] == 8'h08) && (fr[13] == 8'h00) && (fr[14][7:4] == 4'd4)
               && (fr[14][3:0] >= 4'd5);
        hl = fr[14][3:0] * 4;
        foff = {fr[20][4:0], fr[21]};
        if (ctl[2] && ipv4) begin
            s = 0;
            for (int i = 14; i < 14 + hl; i += 2)
                if (i != 24) s += {fr[i], fr[i+1]};
            c = ~fold(s);
            exb[24] = c[15:8];
            exb[25] = c[7:0];
        end
        if (ipv4 && foff == 0 &&
            ((ctl[1] && fr[23] == 8'd6) || (ctl[0] && fr[23] == 8'd17))) begin
            cpos = 14 + hl + ((fr[23] == 8'd6) ? 16 : 6);
            c = ~l4_sum(cpos);
            if (fr[23] == 8'd17 && c == 16'h0000) c = 16'hFFFF;
            exb[cpos]   = c[15:8];
            exb[cpos+1] = c[7:0];
        end
    endtask

    task automatic build(input logic [15:0] etype, input logic [7:0] vihl,
                         input logic [7:0] proto, input logic [12:0] foff,
                         input int plen, input int seed);
        int hl, tl;
        logic [7:0] r;
        hl = (vihl[3:0] >= 5) ? vihl[3:0] * 4 : 20;
        tl = hl + ((proto == 8'd6) ? 20 : 8) + plen;
        flen = (14 + tl < 60) ? 60 : 14 + tl;
        r = 8'(seed * 29 + 3);
        for (int i = 0; i < flen; i++) begin
            r = r * 8'd5 + 8'd59;
            fr[i] = r ^ 8'(i);
        end
        fr[12] = etype[15:8]; fr[13] = etype[7:0];
        fr[14] = vihl;        fr[15] = 8'h00;
        fr[16] = 8'(tl >> 8); fr[17] = 8'(tl);
        fr[20] = {3'b010, foff[12:8]};
        fr[21] = foff[7:0];
        fr[22] = 8'd64;
        fr[23] = proto;
    endtask

    task automatic send(input logic [2:0] ctl, input bit stray);
        gcnt = 0; eof_cnt = 0; eof_idx = -1; sof_err = 0;
        for (int i = 0; i < flen; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_eof   = (i == flen - 1);
            in_data  = fr[i];
            {in_ip_en, in_tcp_en, in_udp_en} = (i == 0) ? ctl : ~ctl; // R7
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        if (stray) begin // R10: bytes offered during replay
            repeat (3) @(negedge clk);
            for (int k = 0; k < 10; k++) begin
                in_valid = 1'b1; in_sof = k[0]; in_eof = (k == 9);
                in_data = 8'hA5 ^ 8'(k); {in_ip_en, in_tcp_en, in_udp_en} = 3'b111;
                @(negedge clk);
            end
            in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        end
        for (int w = 0; w < 3000 && eof_cnt == 0; w++) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    task automatic check_frame(input string rq);
        int bad_i;
        n_vec++;
        if (gcnt != flen || eof_cnt != 1 || eof_idx != flen - 1 || sof_err != 0) begin
            n_bad++;
            $display("FAIL %s R2: framing actual len=%0d eofs=%0d eof_at=%0d sof_err=%0d expected len=%0d eofs=1 eof_at=%0d sof_err=0",
                     rq, gcnt, eof_cnt, eof_idx, sof_err, flen, flen - 1);
        end
        n_vec++;
        bad_i = -1;
        for (int i = 0; i < flen && i < gcnt; i++)
            if (bad_i < 0 && got[i] !== exb[i]) bad_i = i;
        if (bad_i >= 0) begin
            n_bad++;
            $display("FAIL %s: byte %0d actual %02h expected %02h", rq, bad_i, got[bad_i], exb[bad_i]);
        end
    endtask

    task automatic run(input logic [2:0] ctl, input bit stray, input string rq);
        model(ctl);
        send(ctl, stray);
        check_frame(rq);
    endtask

    initial begin
        logic [7:0] protos [3];
        logic [12:0] frags [2];
        int plens [3];
        string tag;
        int seed;
        logic [15:0] s;
        logic [15:0] x;
        protos[0] = 8'd6; protos[1] = 8'd17; protos[2] = 8'd1;
        frags[0] = 13'd0; frags[1] = 13'd185;
        plens[0] = 0; plens[1] = 7; plens[2] = 18;
        in_valid = 0; in_sof = 0; in_eof = 0; in_data = 0;
        in_ip_en = 0; in_tcp_en = 0; in_udp_en = 0;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0 || out_sof !== 1'b0 || out_eof !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: reset outputs actual %b%b%b expected 000", out_valid, out_sof, out_eof);
        end
        rst = 1'b0;
        repeat (10) @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: idle out_valid actual %b expected 0", out_valid);
        end

        // Sweep enables x protocol x fragment x payload length
        seed = 1;
        for (int c = 0; c < 8; c++)
            for (int p = 0; p < 3; p++)
                for (int f = 0; f < 2; f++)
                    for (int l = 0; l < 3; l++) begin
                        build(16'h0800, 8'h45, protos[p], frags[f], plens[l], seed);
                        seed++;
                        tag = "R7";
                        if (c[2]) tag = {tag, " R3"};
                        if (f == 1 && ((c[1] && p == 0) || (c[0] && p == 1))) tag = {tag, " R6"};
                        else if (c[1] && p == 0) tag = {tag, " R4"};
                        else if (c[0] && p == 1) tag = {tag, " R5"};
                        if (c == 0 || p == 2) tag = {tag, " R8"};
                        if (l == 0) tag = {tag, " R9"};
                        if (l == 1) tag = {tag, " R10"};
                        run(3'(c), l == 1, tag);
                    end

        // Longer header (IHL 6) with odd and even payloads
        for (int p = 0; p < 2; p++)
            for (int l = 0; l < 4; l++) begin
                build(16'h0800, 8'h46, protos[p], 13'd0, l, seed);
                seed++;
                run(3'b111, 1'b0, p == 0 ? "R3 R4 ihl6" : "R3 R5 ihl6");
            end

        // Not IPv4: wrong EtherType, wrong version, short IHL
        build(16'h86DD, 8'h45, 8'd6, 13'd0, 5, seed++);
        run(3'b111, 1'b0, "R8 ethertype");
        build(16'h0800, 8'h65, 8'd17, 13'd0, 5, seed++);
        run(3'b111, 1'b0, "R8 version");
        build(16'h0800, 8'h44, 8'd6, 13'd0, 5, seed++);
        run(3'b111, 1'b0, "R8 ihl");
        build(16'h0800, 8'h45, 8'd17, 13'd0, 6, seed++);
        run(3'b110, 1'b0, "R8 proto mismatch");

        // UDP sum forced to zero -> 0xFFFF
        for (int k = 0; k < 3; k++) begin
            build(16'h0800, 8'h45, 8'd17, 13'd0, 4 + k, seed++);
            fr[42] = 8'h00; fr[43] = 8'h00;
            s = l4_sum(40);
            x = 16'hFFFF - s;
            fr[42] = x[15:8]; fr[43] = x[7:0];
            model(3'b001);
            send(3'b001, 1'b0);
            check_frame("R5 zero");
            n_vec++;
            if (got[40] !== 8'hFF || got[41] !== 8'hFF) begin
                n_bad++;
                $display("FAIL R5: zero sum actual %02h%02h expected ffff", got[40], got[41]);
            end
        end

        finish_run();
    end

endmodule